// File: doc/BRIEF.md
# Paired Audio Sample Buffers with Transfer Requests

This block sits between a byte-wide DMA host port and a converter that moves one 16-bit sample per sample-period tick. It holds two independent 16-sample queues: one carries playback samples from the host toward the converter, the other carries captured samples from the converter toward the host. Each queue raises its own transfer request. The host answers a request with an acknowledge plus a write or read strobe, and each strobe moves exactly one byte.

The two request policies differ. The playback queue keeps its request raised until it holds a full set of samples, so it stays as full as it can. The capture queue requests whenever it holds anything, so it drains toward empty every sample period. A slow host makes the capture queue fill up instead of losing data. Samples that reach a full capture queue are dropped and flagged. When playback runs dry, the output either repeats the last sample actually delivered or falls to zero, chosen by an input control bit, and a sticky flag records the event. Dropping a direction's enable empties that queue, lowers its request and clears its flag.

Top module: `audio_xfer_fifo`

## Requirements
- R1: Each queue holds at most 16 samples. The playback request stays high while enabled and fewer than 16 complete samples are held, and drops once the 16th sample completes.
- R2: After a tick removes a sample from a full playback queue, the playback request is high again in the following cycle.
- R3: A sample is two host bytes, the low byte (bits 7:0) first and the high byte (bits 15:8) second. A sample occupies a slot only after its high byte arrives, so a lone low byte does not lower the request.
- R4: Each tick while playback is enabled and the queue is non-empty removes the oldest sample and presents it on `play_sample` from the cycle after the tick.
- R5: A tick that finds the playback queue empty while `hold_last` is 1 presents the last sample taken from the queue.
- R6: A tick that finds the playback queue empty while `hold_last` is 0 presents zero.
- R7: A tick that finds the playback queue empty sets `play_underrun`, which then stays set while playback remains enabled.
- R8: Each tick while capture is enabled stores `cap_sample` if fewer than 16 samples are held. `cap_drq` is high while capture is enabled and the queue is non-empty.
- R9: Capture reads return the oldest sample, low byte first and then high byte. The sample leaves the queue after its high byte is read.
- R10: A capture tick that finds 16 samples held discards the new sample and sets the sticky `cap_overrun`.
- R11: With a direction's enable low, its queue is empty, its request is low, its flag is clear, and `play_sample` is zero.
- R12: Host bytes written while the playback queue is full, or while playback is disabled, have no effect on the samples later presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| play_en | input | 1 | Playback direction enable |
| cap_en | input | 1 | Capture direction enable |
| hold_last | input | 1 | On playback underrun, 1 repeats the last sample, 0 outputs zero |
| tick | input | 1 | One-cycle sample-period pulse from the converter side |
| play_drq | output | 1 | Playback transfer request |
| play_dack | input | 1 | Host acknowledge for playback |
| host_wr | input | 1 | Host write strobe, one byte |
| host_wdata | input | 8 | Host write byte |
| cap_drq | output | 1 | Capture transfer request |
| cap_dack | input | 1 | Host acknowledge for capture |
| host_rd | input | 1 | Host read strobe, one byte |
| host_rdata | output | 8 | Capture byte currently offered to the host |
| play_sample | output | 16 | Sample presented to the output converter |
| cap_sample | input | 16 | Sample from the input converter, taken on tick |
| play_underrun | output | 1 | Sticky playback underrun flag |
| cap_overrun | output | 1 | Sticky capture overrun flag |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that a host strobe arrives only together with its own acknowledge. They also take as given that the host never issues a read and a write in the same cycle to the same direction. The bench drives each strobe for exactly one cycle, on the falling edge, always paired with the matching acknowledge, and keeps `tick` apart from host strobes except in the phase that interleaves them on purpose. Enables and `hold_last` change only between transfers.

// File: rtl/audio_xfer_pkg.sv
package audio_xfer_pkg;
    localparam int SAMPLE_W = 16;
    localparam int BYTE_W   = 8;
    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [BYTE_W-1:0]   byte_t;
endpackage

// File: rtl/axf_queue.sv
module axf_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [PW:0]   count
);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);
    localparam logic [PW-1:0] LAST_IX = PW'(DEPTH-1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [PW:0]             cnt;
    } st_t;

    st_t s_d, s_q;
    logic do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != FULL_CNT);
        do_pop  = pop && (s_q.cnt != '0);
        if (do_push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp = (s_q.wp == LAST_IX) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop)
            s_d.rp = (s_q.rp == LAST_IX) ? '0 : s_q.rp + 1'b1;
        if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
        else if (do_pop && !do_push) s_d.cnt = s_q.cnt - 1'b1;
        if (clr) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.mem[s_q.rp];
    assign count = s_q.cnt;

    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r1_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && count < FULL_CNT) |=> count == $past(count) + 1'b1);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/axf_play.sv
module axf_play
    import audio_xfer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    hold,
    input  logic    tick,
    input  logic    wr_stb,
    input  byte_t   wbyte,
    output logic    drq,
    output sample_t sample,
    output logic    underrun
);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        byte_t   lo;
        logic    ph;
        sample_t last;
        sample_t outv;
        logic    urun;
    } st_t;

    st_t s_d, s_q;
    logic          accept, push, pop, full, empty;
    sample_t       head;
    logic [PW:0]   cnt;

    axf_queue #(.W(SAMPLE_W), .DEPTH(DEPTH)) q_i (
        .clk(clk), .rst_n(rst_n), .clr(!en), .push(push),
        .wdata({wbyte, s_q.lo}), .pop(pop), .rdata(head), .count(cnt)
    );

    always_comb begin
        full   = (cnt == FULL_CNT);
        empty  = (cnt == '0);
        accept = en && wr_stb && !full;
        push   = accept && s_q.ph;
        pop    = en && tick && !empty;
        s_d    = s_q;
        if (accept) begin
            if (!s_q.ph) s_d.lo = wbyte;
            s_d.ph = !s_q.ph;
        end
        if (en && tick) begin
            if (!empty) begin
                s_d.outv = head;
                s_d.last = head;
            end else begin
                s_d.urun = 1'b1;
                s_d.outv = hold ? s_q.last : '0;
            end
        end
        if (!en) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign drq      = en && !full;
    assign sample   = s_q.outv;
    assign underrun = s_q.urun;

    a_r5_hold_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && empty && hold) |=> sample == $past(s_q.last));
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && empty && !hold) |=> sample == '0);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en && underrun) |=> underrun);
    a_r11_play_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sample == '0 && !underrun));
endmodule

// File: rtl/axf_cap.sv
module axf_cap
    import audio_xfer_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    tick,
    input  sample_t sample_in,
    input  logic    rd_stb,
    output logic    drq,
    output byte_t   rbyte,
    output logic    overrun
);
    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    typedef struct packed {
        logic ph;
        logic ovr;
    } st_t;

    st_t s_d, s_q;
    logic        full, empty, push, take, pop;
    sample_t     head;
    logic [PW:0] cnt;

    axf_queue #(.W(SAMPLE_W), .DEPTH(DEPTH)) q_i (
        .clk(clk), .rst_n(rst_n), .clr(!en), .push(push),
        .wdata(sample_in), .pop(pop), .rdata(head), .count(cnt)
    );

    always_comb begin
        full  = (cnt == FULL_CNT);
        empty = (cnt == '0);
        push  = en && tick && !full;
        take  = en && rd_stb && !empty;
        pop   = take && s_q.ph;
        s_d   = s_q;
        if (take)               s_d.ph  = !s_q.ph;
        if (en && tick && full) s_d.ovr = 1'b1;
        if (!en) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign drq     = en && !empty;
    assign rbyte   = s_q.ph ? head[15:8] : head[7:0];
    assign overrun = s_q.ovr;

    a_r10_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && full) |=> overrun);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en && overrun) |=> overrun);
    a_r11_cap_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drq && !overrun));
endmodule

// File: rtl/audio_xfer_fifo.sv
module audio_xfer_fifo
    import audio_xfer_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        play_en,
    input  logic        cap_en,
    input  logic        hold_last,
    input  logic        tick,
    output logic        play_drq,
    input  logic        play_dack,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic        cap_drq,
    input  logic        cap_dack,
    input  logic        host_rd,
    output logic [7:0]  host_rdata,
    output logic [15:0] play_sample,
    input  logic [15:0] cap_sample,
    output logic        play_underrun,
    output logic        cap_overrun
);
    axf_play #(.DEPTH(DEPTH)) play_i (
        .clk(clk), .rst_n(rst_n), .en(play_en), .hold(hold_last), .tick(tick),
        .wr_stb(play_dack && host_wr), .wbyte(host_wdata), .drq(play_drq),
        .sample(play_sample), .underrun(play_underrun)
    );

    axf_cap #(.DEPTH(DEPTH)) cap_i (
        .clk(clk), .rst_n(rst_n), .en(cap_en), .tick(tick),
        .sample_in(cap_sample), .rd_stb(cap_dack && host_rd), .drq(cap_drq),
        .rbyte(host_rdata), .overrun(cap_overrun)
    );
endmodule

// File: tb/audio_xfer_fifo_tb.sv
module audio_xfer_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic clk = 0, rst_n = 0;
    logic play_en = 0, cap_en = 0, hold_last = 0, tick = 0;
    logic play_dack = 0, host_wr = 0, cap_dack = 0, host_rd = 0;
    logic [7:0] host_wdata = 0;
    logic [15:0] cap_sample = 0;
    logic play_drq, cap_drq, play_underrun, cap_overrun;
    logic [7:0] host_rdata;
    logic [15:0] play_sample;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_xfer_fifo #(.DEPTH(DEPTH)) dut_i (.*);

    function automatic logic [15:0] pv(int k);
        return 16'(k * 3869 + 14855);
    endfunction
    function automatic logic [15:0] cv(int k);
        return 16'(k * 40503 + 291);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        play_dack = 1; host_wr = 1; host_wdata = b;
        @(negedge clk);
        play_dack = 0; host_wr = 0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        cap_dack = 1; host_rd = 1;
        #1 b = host_rdata;
        @(negedge clk);
        cap_dack = 0; host_rd = 0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lo, hi;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!play_drq && !cap_drq && play_sample == 0 && !play_underrun && !cap_overrun,
            "R11 reset", {play_drq, cap_drq, play_underrun, cap_overrun}, 0);

        // playback fill
        play_en = 1;
        @(negedge clk);
        chk(play_drq == 1, "R1 drq on enable", play_drq, 1);
        for (int k = 0; k < DEPTH; k++) begin
            wr_byte(pv(k)[7:0]);
            if (k == DEPTH-1) chk(play_drq == 1, "R3 low byte alone keeps drq", play_drq, 1);
            wr_byte(pv(k)[15:8]);
            if (k < DEPTH-1) chk(play_drq == 1, "R1 drq while not full", play_drq, 1);
        end
        chk(play_drq == 0, "R1 drq drops at 16", play_drq, 0);
        wr_byte(8'hEE); wr_byte(8'hEE);  // R12 ignored while full

        for (int k = 0; k < DEPTH; k++) begin
            do_tick();
            chk(play_sample == pv(k), "R4 playback order", play_sample, pv(k));
            if (k == 0) chk(play_drq == 1, "R2 drq after slot freed", play_drq, 1);
        end
        hold_last = 0;
        do_tick();
        chk(play_sample == 0, "R6 zero on underrun (R12 junk absent)", play_sample, 0);
        chk(play_underrun == 1, "R7 underrun flag", play_underrun, 1);
        wr_byte(8'h34); wr_byte(8'h12);
        do_tick();
        chk(play_sample == 16'h1234, "R4 sample after underrun", play_sample, 16'h1234);
        chk(play_underrun == 1, "R7 flag sticky", play_underrun, 1);
        hold_last = 1;
        for (int r = 0; r < 3; r++) begin
            do_tick();
            chk(play_sample == 16'h1234, "R5 hold last", play_sample, 16'h1234);
        end
        hold_last = 0;
        do_tick();
        chk(play_sample == 0, "R6 zero after hold off", play_sample, 0);
        hold_last = 1;
        do_tick();
        chk(play_sample == 16'h1234, "R5 last valid kept", play_sample, 16'h1234);

        // disable flush and ignore writes while off
        wr_byte(8'h11); wr_byte(8'h22);
        play_en = 0;
        @(negedge clk);
        chk(!play_drq && !play_underrun && play_sample == 0, "R11 play disable",
            {play_drq, play_underrun, play_sample}, 0);
        wr_byte(8'h55); wr_byte(8'h66);
        play_en = 1; hold_last = 1;
        do_tick();
        chk(play_sample == 0, "R12 writes while disabled ignored", play_sample, 0);
        chk(play_underrun == 1, "R7 underrun after flush", play_underrun, 1);
        play_en = 0;

        // capture: slow host
        cap_en = 1;
        @(negedge clk);
        chk(cap_drq == 0, "R8 drq low when empty", cap_drq, 0);
        for (int k = 0; k < DEPTH + 4; k++) begin
            cap_sample = cv(k);
            do_tick();
            if (k == 0) chk(cap_drq == 1, "R8 drq after capture", cap_drq, 1);
            if (k == DEPTH-1) chk(cap_overrun == 0, "R10 no overrun at 16", cap_overrun, 0);
            if (k == DEPTH) chk(cap_overrun == 1, "R10 overrun at 17", cap_overrun, 1);
        end
        for (int k = 0; k < DEPTH; k++) begin
            rd_byte(lo); rd_byte(hi);
            chk({hi, lo} == cv(k), "R9 capture order", {hi, lo}, cv(k));
        end
        chk(cap_drq == 0, "R8 drq low after drain", cap_drq, 0);
        chk(cap_overrun == 1, "R10 overrun sticky", cap_overrun, 1);

        // interleaved capture
        for (int k = 0; k < 6; k++) begin
            cap_sample = cv(100 + k);
            do_tick();
            rd_byte(lo);
            chk(cap_drq == 1, "R9 sample held until high byte", cap_drq, 1);
            rd_byte(hi);
            chk({hi, lo} == cv(100 + k), "R9 interleaved", {hi, lo}, cv(100 + k));
        end
        cap_sample = cv(7); do_tick();
        cap_en = 0;
        @(negedge clk);
        chk(!cap_drq && !cap_overrun, "R11 cap disable", {cap_drq, cap_overrun}, 0);
        cap_en = 1;
        @(negedge clk);
        chk(cap_drq == 0, "R11 cap flushed", cap_drq, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule